// File: doc/BRIEF.md
# Output Gain Shift and Rounder

This block sits at the output of a resampler. The resampler produces a wide signed accumulator value on two lanes, in-phase (I) and quadrature (Q). The block multiplies each lane by a power of two, from 2^0 to 2^15, to set the output gain. It then rounds the product to 12, 16, 20 or 24 significant bits. The result is placed at the top of a 24-bit output word.

One 6-bit control word holds both settings. The block samples this word together with each accepted input beat, so software can change the gain between beats without corrupting data already in flight. An overflow at either step clamps the output to the extreme value of the right sign; the output never wraps.

Data moves through a two-stage valid/ready pipeline. Both stages advance together when the output is empty or is being taken, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new input beat is accepted. An input beat is transferred on a rising clock edge where both `in_valid` and `in_ready` are high.

Top module: `gain_round_out`

## Requirements
- R1: After `rst_n` is released, `out_valid` is low and `in_ready` is high until a beat has been accepted.
- R2: Each lane's result equals the signed 40-bit input multiplied by 2^s, where s is `cfg_word[5:2]` (0 to 15), and then rounded as in R3 and R4.
- R3: `cfg_word[1:0]` selects the kept width K. Code 0 keeps 12 bits, 1 keeps 16, 2 keeps 20 and 3 keeps 24. The K kept bits are bits 39 down to 40-K of the shifted value. They sit at the top of the 24-bit output, and the lower 24-K output bits are zero.
- R4: Rounding is half-up. Before truncation, 2^(39-K) is added to the shifted value. An exact half therefore rounds toward positive infinity, for negative values as well.
- R5: If the shifted value lies outside the signed 40-bit range, it is clamped to 2^39-1 or to -2^39 before rounding. A positive overflow gives K-1 ones under a zero sign bit. A negative overflow gives 0x800000.
- R6: If rounding carries past the largest positive K-bit value, the output is the positive saturation value of R5 and does not wrap to a negative value.
- R7: The I and Q lanes are computed identically and independently from `in_i` and `in_q`, using the same control word.
- R8: With `out_ready` held high, a beat accepted at one clock edge appears on the outputs two edges later. One beat is accepted every cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_i`, `out_q` and `out_valid` stay stable and `in_ready` is low.
- R10: The control word is captured with each accepted beat. Changing it on later beats does not alter beats already accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 6 | Bits 5:2 give the up-shift amount, bits 1:0 give the width code |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block accepts the input beat this cycle |
| in_i | input | 40 | Signed I accumulator value |
| in_q | input | 40 | Signed Q accumulator value |
| out_valid | output | 1 | Output beat is present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_i | output | 24 | Rounded I result, kept bits at the top |
| out_q | output | 24 | Rounded Q result, kept bits at the top |

## Verification
The bench sweeps every shift amount and every width code. For each pair it sends edge values such as exact half-LSB ties, the values one below a tie, the most negative and most positive inputs, and near-top values that carry out during rounding. A design that rounds half away from zero would be wrong on negative ties. A design that wraps instead of clamping would turn large positive results negative at high shifts or after rounding. A design that forgets to clear the bits below the kept width would leave residue in the low output bits. The pipeline is driven with random input gaps and random `out_ready` stalls while the control word changes on every beat. A design that dropped, duplicated or altered a stalled beat, or applied a later control word to an earlier beat, would break the in-order comparison.

// File: rtl/gro_pkg.sv
package gro_pkg;

  // Rounding width codes, taken from the low two bits of the control word
  typedef enum logic [1:0] {
    RND_NARROWEST = 2'd0,
    RND_NARROW    = 2'd1,
    RND_WIDE      = 2'd2,
    RND_FULL      = 2'd3
  } rnd_code_e;

  localparam int unsigned N_RND_CODES = 4;
  localparam int unsigned N_LANES     = 2;

  // Number of bits kept for a width code: the full width, less one step for each code below the top
  function automatic int keep_width(input int out_w, input int step, input int code);
    return out_w - (N_RND_CODES - 1 - code) * step;
  endfunction

endpackage

// File: rtl/gro_upshift.sv
// Up-shift with clamp to the signed accumulator range (combinational)
module gro_upshift #(
  parameter int ACC_W = 40,
  parameter int SH_W  = 4
) (
  input  logic [ACC_W-1:0] x,
  input  logic [SH_W-1:0]  sh,
  output logic [ACC_W-1:0] y
);
  localparam int MAX_SH = (1 << SH_W) - 1;
  localparam int WIDE   = ACC_W + MAX_SH;
  localparam int TOP_N  = WIDE - ACC_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic [WIDE-1:0]  ext;
  logic [WIDE-1:0]  shl;
  logic [TOP_N-1:0] upper;
  logic             ovf;

  always_comb begin
    ext   = {{MAX_SH{x[ACC_W-1]}}, x};
    shl   = ext << sh;
    upper = shl[WIDE-1:ACC_W-1];
    // all bits above the new sign must match it
    ovf   = !((&upper) || !(|upper));
    if (ovf) y = shl[WIDE-1] ? NEG_LIM : POS_LIM;
    else     y = shl[ACC_W-1:0];
  end
endmodule

// File: rtl/gro_rounder.sv
// Half-up rounding to one of four kept widths with positive saturation (combinational)
module gro_rounder
  import gro_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int OUT_W    = 24,
  parameter int RND_STEP = 4
) (
  input  logic [ACC_W-1:0] y,
  input  logic [1:0]       code,
  output logic [OUT_W-1:0] q
);
  logic [OUT_W-1:0] cand [N_RND_CODES];

  for (genvar g = 0; g < N_RND_CODES; g++) begin : g_width
    localparam int K    = keep_width(OUT_W, RND_STEP, g);
    localparam int LSB  = ACC_W - K;
    localparam logic [ACC_W:0]   HALF = (ACC_W+1)'(1) << (LSB - 1);
    localparam logic [OUT_W-1:0] MASK = ~((OUT_W'(1) << (OUT_W - K)) - OUT_W'(1));
    localparam logic [OUT_W-1:0] PSAT = {1'b0, {(OUT_W-1){1'b1}}} & MASK;

    logic [ACC_W:0] sum;
    logic           carry_ovf;

    always_comb begin
      sum       = {y[ACC_W-1], y} + HALF;
      carry_ovf = sum[ACC_W] ^ sum[ACC_W-1];
      cand[g]   = carry_ovf ? PSAT : (sum[ACC_W-1 -: OUT_W] & MASK);
    end
  end

  assign q = cand[code];
endmodule

// File: rtl/gro_flow.sv
// Two-stage valid tracking with a single advance signal for the whole pipeline
module gro_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic s1_valid,
  output logic out_valid,
  output logic ld1,
  output logic ld2
);
  logic v1, v2;
  logic adv;

  assign adv       = !v2 || out_ready;
  assign in_ready  = adv;
  assign ld1       = adv && in_valid;
  assign ld2       = adv && v1;
  assign s1_valid  = v1;
  assign out_valid = v2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end
endmodule

// File: rtl/gain_round_out.sv
module gain_round_out
  import gro_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int OUT_W    = 24,
  parameter int SH_W     = 4,
  parameter int RND_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SH_W+1:0]  cfg_word,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ACC_W-1:0] in_i,
  input  logic [ACC_W-1:0] in_q,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_i,
  output logic [OUT_W-1:0] out_q
);
  logic             s1_valid;
  logic             ld1, ld2;
  logic [SH_W-1:0]  in_sh;
  logic [1:0]       in_code;
  logic [1:0]       s1_code;
  logic [1:0]       s2_code;
  logic [ACC_W-1:0] lane_x [N_LANES];
  logic [ACC_W-1:0] s1_y   [N_LANES];
  logic [OUT_W-1:0] s2_q   [N_LANES];

  assign in_sh     = cfg_word[SH_W+1:2];
  assign in_code   = cfg_word[1:0];
  assign lane_x[0] = in_i;
  assign lane_x[1] = in_q;

  gro_flow u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .s1_valid  (s1_valid),
    .out_valid (out_valid),
    .ld1       (ld1),
    .ld2       (ld2)
  );

  // control word travels with its beat (R10)
  always_ff @(posedge clk) begin
    if (ld1) s1_code <= in_code;
    if (ld2) s2_code <= s1_code;
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [ACC_W-1:0] y_c;
    logic [OUT_W-1:0] q_c;

    gro_upshift #(.ACC_W(ACC_W), .SH_W(SH_W)) u_shift (
      .x  (lane_x[g]),
      .sh (in_sh),
      .y  (y_c)
    );

    always_ff @(posedge clk) begin
      if (ld1) s1_y[g] <= y_c;
    end

    gro_rounder #(.ACC_W(ACC_W), .OUT_W(OUT_W), .RND_STEP(RND_STEP)) u_round (
      .y    (s1_y[g]),
      .code (s1_code),
      .q    (q_c)
    );

    always_ff @(posedge clk) begin
      if (ld2) s2_q[g] <= q_c;
    end
  end

  assign out_i = s2_q[0];
  assign out_q = s2_q[1];
endmodule

// File: rtl/gain_round_out_chk.sv
module gain_round_out_chk #(
  parameter int OUT_W    = 24,
  parameter int RND_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_i,
  input logic [OUT_W-1:0] out_q,
  input logic [1:0]       s2_code,
  input logic             s1_valid,
  input logic             s1_msb_i
);
  localparam logic [OUT_W-1:0] LOW0 = (OUT_W'(1) << (3*RND_STEP)) - OUT_W'(1);

  // R1: pipeline empty when reset is released
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);

  // R9: stalled beat stays put
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  // R9: no acceptance while stalled
  a_r9_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3: narrowest code leaves low bits clear
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && s2_code == 2'd0 |-> ((out_i & LOW0) == '0) && ((out_q & LOW0) == '0));

  // R6: a non-negative value never rounds to a negative output
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && in_ready && !s1_msb_i |=> !out_i[OUT_W-1]);
endmodule

bind gain_round_out gain_round_out_chk #(.OUT_W(OUT_W), .RND_STEP(RND_STEP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_i     (out_i),
  .out_q     (out_q),
  .s2_code   (s2_code),
  .s1_valid  (s1_valid),
  .s1_msb_i  (s1_y[0][ACC_W-1])
);

// File: tb/gain_round_out_test.sv
`timescale 1ns/1ps
module gain_round_out_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_word = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] in_i = '0;
  logic [39:0] in_q = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_i;
  logic [23:0] out_q;

  always #10 clk = ~clk;

  gain_round_out uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit lat_mode = 0;
  bit rdy_rand = 0;
  int cyc = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  typedef struct {
    logic [39:0] xi;
    logic [39:0] xq;
    logic [5:0]  cf;
    int          t;
  } beat_t;
  beat_t pend[$];

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // Arithmetic model: scale by 2^s, clamp, add half LSB, floor, clamp, place at top
  function automatic logic [23:0] model(input logic [39:0] x, input int s, input int c, output string tag);
    longint y, r, maxp, minn, half, rmax;
    int k, l;
    k = 12 + 4*c;
    l = 40 - k;
    maxp = (64'sd1 <<< 39) - 1;
    minn = -(64'sd1 <<< 39);
    y = longint'($signed(x)) * (64'sd1 <<< s);
    tag = "R2/R3";
    if (y > maxp) begin y = maxp; tag = "R5"; end
    if (y < minn) begin y = minn; tag = "R5"; end
    half = 64'sd1 <<< (l - 1);
    if (tag != "R5" && ((y & ((64'sd1 <<< l) - 1)) == half)) tag = "R4";
    r = (y + half) >>> l;
    rmax = (64'sd1 <<< (k - 1)) - 1;
    if (r > rmax) begin r = rmax; if (tag != "R5") tag = "R6"; end
    return 24'(r <<< (24 - k));
  endfunction

  function automatic logic [39:0] val(input int k);
    case (k)
      0:  return 40'h0;
      1:  return 40'h1;
      2:  return 40'hFF_FFFF_FFFF;
      3:  return 40'h7F_FFFF_FFFF;
      4:  return 40'h80_0000_0000;
      5:  return 40'h00_0800_0000;
      6:  return 40'h00_07FF_FFFF;
      7:  return 40'hFF_F800_0000;
      8:  return 40'h00_1800_0000;
      9:  return 40'hFF_E800_0000;
      10: return 40'h00_0080_0000;
      11: return 40'hFF_FF80_0000;
      12: return 40'h00_0008_0000;
      13: return 40'hFF_FFF8_0000;
      14: return 40'h00_0000_8000;
      15: return 40'hFF_FFFF_8000;
      16: return 40'h7F_F800_0000;
      17: return 40'h7F_FFFF_8000;
      18: return 40'h7F_FF80_0000;
      19: return 40'h7F_FFF8_0000;
      20: return 40'h00_FFFF_FFFF;
      21: return 40'hFF_0000_0000;
      22: return 40'h00_0001_0000;
      23: return 40'hC0_0000_0001;
      default: return 40'(64'(k) * 64'h9E37_79B9_7F4A_7C15 >> 9);
    endcase
  endfunction

  // Monitor: sample away from the active edge
  logic        stall_prev = 0;
  logic [23:0] held_i, held_q;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (stall_prev) begin
        check(out_valid, "R9 valid held", {23'b0, out_valid}, 24'd1);
        check(out_i == held_i, "R9 out_i held", out_i, held_i);
        check(out_q == held_q, "R9 out_q held", out_q, held_q);
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R9 in_ready low in stall", {23'b0, in_ready}, 24'd0);
      stall_prev = out_valid && !out_ready;
      held_i = out_i;
      held_q = out_q;
      if (in_valid && in_ready) begin
        beat_t b;
        b.xi = in_i; b.xq = in_q; b.cf = cfg_word; b.t = cyc;
        pend.push_back(b);
      end
      if (out_valid && out_ready) begin
        if (pend.size() == 0) begin
          check(0, "R8 unexpected output beat", out_i, 24'd0);
        end else begin
          beat_t b;
          string ti, tq;
          logic [23:0] ei, eq;
          b = pend.pop_front();
          ei = model(b.xi, int'(b.cf[5:2]), int'(b.cf[1:0]), ti);
          eq = model(b.xq, int'(b.cf[5:2]), int'(b.cf[1:0]), tq);
          check(out_i == ei, {ti, " lane I"}, out_i, ei);
          check(out_q == eq, {tq, " R7 lane Q"}, out_q, eq);
          if (lat_mode)
            check(cyc == b.t + 2, "R8 latency / R10 cfg per beat", 24'(cyc - b.t), 24'd2);
        end
      end
    end
  end

  // Downstream readiness
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      out_ready = rdy_rand ? (lfsr[1:0] != 2'b00) : 1'b1;
    end
  end

  task automatic send(input logic [39:0] xi, input logic [39:0] xq, input logic [5:0] cf);
    in_valid = 1'b1;
    in_i = xi;
    in_q = xq;
    cfg_word = cf;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog R8", 24'd0, 24'd1);
    report();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", {23'b0, out_valid}, 24'd0);
    check(in_ready, "R1 in_ready after reset", {23'b0, in_ready}, 24'd1);
    @(posedge clk);
    #2;

    // Back-to-back beats, control word changing each beat, out_ready high
    lat_mode = 1;
    for (int k = 0; k < 12; k++)
      send(val(k), ~val(k + 5), 6'((k * 7) % 64));
    repeat (4) @(posedge clk);
    #2;
    lat_mode = 0;

    // Sweep every shift and width code with random gaps and stalls
    rdy_rand = 1;
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 32; k++) begin
          send(val(k), ~val((k + 7) % 32), {4'(s), 2'(c)});
          if (lfsr[7:5] == 3'b000) begin
            @(posedge clk);
            #2;
          end
        end
    rdy_rand = 0;
    for (int w = 0; w < 50 && pend.size() > 0; w++) @(posedge clk);
    @(negedge clk);
    check(pend.size() == 0, "R8 all beats delivered", 24'(pend.size()), 24'd0);
    report();
    $finish;
  end
endmodule